// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control for a 12-bit successive-approximation converter. Software launches a cycle by setting a start/busy bit. A 3-bit acquisition-length field optionally holds the sample switch closed for a set number of conversion-clock periods. The sequencer then opens the switch and resolves the result from the most significant bit down, one bit per conversion-clock period. It does this by presenting a one-hot trial bit and a trial code to the external DAC array and reading back the comparator decision. On completion it loads the result register, drops the busy bit and raises a sticky interrupt flag.

After every completion or abort the sequencer waits two conversion-clock periods. It then discharges the capacitor array for one period and returns to sampling on its own. A start written during that wait is held and serviced as soon as sampling resumes. Clearing the busy bit mid-cycle aborts and leaves the result register untouched. The conversion clock enters as a single-cycle enable (`conv_tick`). The comparator is the input `comp_in`, which is 1 when the analog input is at or above the trial code.

The states are OFF, DISCHARGE, SAMPLE, SAMPLE_TIMED, CONVERT, LOAD and RECOVER. The transitions are:
- OFF to DISCHARGE when enabled.
- DISCHARGE to SAMPLE after one tick.
- SAMPLE to CONVERT on a start with a zero acquisition length.
- SAMPLE to SAMPLE_TIMED on a start with a nonzero length.
- SAMPLE_TIMED to CONVERT after the programmed ticks.
- SAMPLE_TIMED or CONVERT to RECOVER when aborted.
- CONVERT to LOAD after the bit-0 tick.
- LOAD to RECOVER after one clock.
- RECOVER to DISCHARGE after two ticks.
- Any state to OFF when the enable drops.

Top module: `sar_conv_seq`

## Requirements
- R1: With acquisition select 000, the sample switch opens (CONVERT) on the second clock edge after the control write that sets the start bit, and no acquisition periods are spent.
- R2: With a nonzero select, the switch stays closed for N conversion ticks after the start before conversion begins: 001→2, 010→4, 011→6, 100→8, 101→12, 110→16, 111→20.
- R3: While converting, `sample_sw` is 0 and `busy` is 1.
- R4: Bits are resolved MSB first, one per conversion tick, 12 ticks in all. `trial_bits` is one-hot at bit 11-k during the k-th period. `dac_code` is the bits kept so far OR the trial bit. A bit is kept when `comp_in` is 1.
- R5: One clock after the bit-0 tick, `result` holds the converted code, `busy` is 0, `irq_flag` is 1 and `sample_sw` is 1.
- R6: Writing the start bit to 0 during SAMPLE_TIMED or CONVERT aborts the cycle, clears `busy` and leaves `result` unchanged.
- R7: After completion or abort, exactly 2 conversion ticks pass with `discharge` low before the array is discharged, and sampling (`sample_sw` = 1) resumes automatically afterwards.
- R8: Before every sampling phase, including the one after enable, `discharge` is high for exactly one conversion tick with the switch open.
- R9: A start written during RECOVER or DISCHARGE keeps `busy` at 1 and is serviced when SAMPLE is reached, after the full recovery wait.
- R10: A start written while `enable` is low, or in the same cycle that `enable` rises, is ignored. Dropping `enable` clears `busy` and opens the switch.
- R11: A write to the result register takes effect on the next clock, and `result` reads back the last value loaded by software or by a conversion.
- R12: `irq_flag` stays set until `irq_clr` is pulsed, and an abort does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter power/enable |
| conv_tick | input | 1 | One-cycle strobe per conversion-clock period |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_go | input | 1 | Start/busy bit value written |
| ctl_acq | input | 3 | Acquisition-length select written |
| res_wr | input | 1 | Result register write strobe |
| res_wdata | input | 12 | Result value written by software |
| irq_clr | input | 1 | Clears the interrupt flag |
| comp_in | input | 1 | Comparator decision: input ≥ trial code |
| busy | output | 1 | Start/busy bit readback |
| sample_sw | output | 1 | Sample switch closed |
| discharge | output | 1 | Capacitor array discharge strobe |
| trial_bits | output | 12 | One-hot bit under trial |
| dac_code | output | 12 | Trial code for the DAC array |
| result | output | 12 | Result register readback |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
Conversions are driven with analog codes of zero, full scale, mid-scale and an alternating pattern, against a comparator modelled in the bench. This separates a correct MSB-first search from a stuck, reversed or off-by-one bit walk. Several acquisition selects are tried so that the period count distinguishes a zero-length start from a timed one and catches a wrong length mapping. Aborts are issued both in timed sampling and mid-conversion, preloaded results expose any partial update, and a start written during recovery shows whether the wait is shortened or the request lost.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int ACQ_W = 5;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DISCH,
        ST_SAMPLE,
        ST_SAMPLE_T,
        ST_CONVERT,
        ST_LOAD,
        ST_RECOVER
    } seq_state_e;

    // Acquisition length in conversion-clock periods for each select code.
    function automatic logic [ACQ_W-1:0] acq_periods(input logic [2:0] sel);
        logic [ACQ_W-1:0] n;
        unique case (sel)
            3'd0: n = ACQ_W'(0);
            3'd1: n = ACQ_W'(2);
            3'd2: n = ACQ_W'(4);
            3'd3: n = ACQ_W'(6);
            3'd4: n = ACQ_W'(8);
            3'd5: n = ACQ_W'(12);
            3'd6: n = ACQ_W'(16);
            default: n = ACQ_W'(20);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sar_tick_counter.sv
module sar_tick_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             advance,
    input  logic             comp_in,
    output logic [RES_W-1:0] trial_mask,
    output logic [RES_W-1:0] code,
    output logic [RES_W-1:0] kept,
    output logic             last_bit
);

    localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] kept_q;
    logic [RES_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kept_q <= '0;
            mask_q <= '0;
        end else if (start) begin
            kept_q <= '0;
            mask_q <= MSB_MASK;
        end else if (advance) begin
            if (comp_in) begin
                kept_q <= kept_q | mask_q;
            end
            mask_q <= mask_q >> 1;
        end
    end

    assign trial_mask = mask_q;
    assign code       = kept_q | mask_q;
    assign kept       = kept_q;
    assign last_bit   = mask_q[0];

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int CNT_W = ACQ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             go,
    input  logic             tick,
    input  logic [CNT_W-1:0] acq_len,
    input  logic [CNT_W-1:0] tcount,
    input  logic             last_bit,
    output seq_state_e       state,
    output logic             cnt_clear,
    output logic             conv_start,
    output logic             conv_step,
    output logic             load_result,
    output logic             sample_sw,
    output logic             discharge
);

    localparam logic [CNT_W-1:0] RECOVER_TICKS = CNT_W'(2);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:      state_d = ST_DISCH;
                ST_DISCH:    if (tick) state_d = ST_SAMPLE;
                ST_SAMPLE: begin
                    if (go) begin
                        state_d = (acq_len == '0) ? ST_CONVERT : ST_SAMPLE_T;
                    end
                end
                ST_SAMPLE_T: begin
                    if (!go) begin
                        state_d = ST_RECOVER;
                    end else if (tick && (tcount == acq_len - 1'b1)) begin
                        state_d = ST_CONVERT;
                    end
                end
                ST_CONVERT: begin
                    if (!go) begin
                        state_d = ST_RECOVER;
                    end else if (tick && last_bit) begin
                        state_d = ST_LOAD;
                    end
                end
                ST_LOAD:     state_d = ST_RECOVER;
                ST_RECOVER: begin
                    if (tick && (tcount == RECOVER_TICKS - 1'b1)) begin
                        state_d = ST_DISCH;
                    end
                end
                default:     state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        sample_sw   = 1'b0;
        discharge   = 1'b0;
        conv_step   = 1'b0;
        load_result = 1'b0;
        unique case (state_q)
            ST_OFF:      ;
            ST_DISCH:    discharge = 1'b1;
            ST_SAMPLE:   sample_sw = 1'b1;
            ST_SAMPLE_T: sample_sw = 1'b1;
            ST_CONVERT:  conv_step = tick && go;
            ST_LOAD: begin
                sample_sw   = 1'b1;
                load_result = 1'b1;
            end
            ST_RECOVER:  sample_sw = 1'b1;
            default:     ;
        endcase
    end

    assign state      = state_q;
    assign cnt_clear  = (state_d != state_q);
    assign conv_start = (state_d == ST_CONVERT) && (state_q != ST_CONVERT);

    // The array is discharged right before each sampling phase.
    assert_disch_before_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && $past(state_q) != ST_SAMPLE) |-> ($past(state_q) == ST_DISCH));

    // Recovery never runs past its two ticks.
    assert_recover_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |-> (tcount < RECOVER_TICKS));

    // Timed sampling never outlasts the selected length.
    assert_acq_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE_T) |-> (tcount < acq_len));

    // An abort leaves sampling or conversion for recovery.
    assert_abort_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONVERT || state_q == ST_SAMPLE_T) && !go && enable) |=> (state_q == ST_RECOVER));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             conv_tick,
    input  logic             ctl_wr,
    input  logic             ctl_go,
    input  logic [2:0]       ctl_acq,
    input  logic             res_wr,
    input  logic [RES_W-1:0] res_wdata,
    input  logic             irq_clr,
    input  logic             comp_in,
    output logic             busy,
    output logic             sample_sw,
    output logic             discharge,
    output logic [RES_W-1:0] trial_bits,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             irq_flag
);

    localparam int CNT_W = ACQ_W;

    logic             go_q;
    logic [2:0]       acq_sel_q;
    logic             enable_q;
    logic [RES_W-1:0] result_q;
    logic             irq_q;

    seq_state_e       state;
    logic             cnt_clear;
    logic             conv_start;
    logic             conv_step;
    logic             load_result;
    logic [CNT_W-1:0] tcount;
    logic [CNT_W-1:0] acq_len;
    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] kept;
    logic             last_bit;
    logic             conv_active;

    assign acq_len     = acq_periods(acq_sel_q);
    assign conv_active = (state == ST_CONVERT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= 1'b0;
            go_q      <= 1'b0;
            acq_sel_q <= '0;
        end else begin
            enable_q <= enable;
            if (ctl_wr) begin
                acq_sel_q <= ctl_acq;
            end
            if (!enable || load_result) begin
                go_q <= 1'b0;
            end else if (ctl_wr) begin
                if (!ctl_go) begin
                    go_q <= 1'b0;
                end else if (enable_q) begin
                    go_q <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (load_result) begin
                result_q <= kept;
            end else if (res_wr) begin
                result_q <= res_wdata;
            end
            if (load_result) begin
                irq_q <= 1'b1;
            end else if (irq_clr) begin
                irq_q <= 1'b0;
            end
        end
    end

    sar_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .go          (go_q),
        .tick        (conv_tick),
        .acq_len     (acq_len),
        .tcount      (tcount),
        .last_bit    (last_bit),
        .state       (state),
        .cnt_clear   (cnt_clear),
        .conv_start  (conv_start),
        .conv_step   (conv_step),
        .load_result (load_result),
        .sample_sw   (sample_sw),
        .discharge   (discharge)
    );

    sar_tick_counter #(.CNT_W(CNT_W)) u_ticks (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (conv_tick),
        .count (tcount)
    );

    sar_bit_engine #(.RES_W(RES_W)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (conv_start),
        .advance    (conv_step),
        .comp_in    (comp_in),
        .trial_mask (mask),
        .code       (dac_code),
        .kept       (kept),
        .last_bit   (last_bit)
    );

    assign busy       = go_q;
    assign result     = result_q;
    assign irq_flag   = irq_q;
    assign trial_bits = conv_active ? mask : '0;

    // Exactly one bit is under trial throughout conversion.
    assert_trial_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_active |-> $onehot(trial_bits));

    // Completion drops busy as the flag rises.
    assert_done_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> (!busy && sample_sw));

    // An abort write leaves the result register alone.
    assert_abort_keeps_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && ctl_wr && !ctl_go && !res_wr) |=> $stable(result));

    // A start on the enable edge or while disabled is dropped.
    assert_start_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_go && !enable_q) |=> !busy);

    // The flag holds until software clears it.
    assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         conv_tick = 1'b0;
    logic         ctl_wr = 1'b0;
    logic         ctl_go = 1'b0;
    logic [2:0]   ctl_acq = 3'd0;
    logic         res_wr = 1'b0;
    logic [W-1:0] res_wdata = '0;
    logic         irq_clr = 1'b0;
    logic         comp_in;
    logic         busy;
    logic         sample_sw;
    logic         discharge;
    logic [W-1:0] trial_bits;
    logic [W-1:0] dac_code;
    logic [W-1:0] result;
    logic         irq_flag;

    logic [W-1:0] vin = '0;
    int checks = 0;
    int errors = 0;
    int phase = 0;
    bit mon_on = 0;
    int acq_cnt = 0;
    int conv_cnt = 0;
    bit order_bad = 0;
    int rec_cnt = 0;
    int dis_cnt = 0;

    always #5 clk = ~clk;

    assign comp_in = (dac_code <= vin);

    sar_conv_seq #(.RES_W(W)) i_sar_conv_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .conv_tick  (conv_tick),
        .ctl_wr     (ctl_wr),
        .ctl_go     (ctl_go),
        .ctl_acq    (ctl_acq),
        .res_wr     (res_wr),
        .res_wdata  (res_wdata),
        .irq_clr    (irq_clr),
        .comp_in    (comp_in),
        .busy       (busy),
        .sample_sw  (sample_sw),
        .discharge  (discharge),
        .trial_bits (trial_bits),
        .dac_code   (dac_code),
        .result     (result),
        .irq_flag   (irq_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge, set the tick for the coming rising edge,
    // and count ticks against the state seen now.
    task automatic step();
        @(negedge clk);
        phase = (phase + 1) % 4;
        conv_tick = (phase == 0);
        if (mon_on && conv_tick) begin
            if (busy && sample_sw && conv_cnt == 0) begin
                acq_cnt++;
            end else if (busy && !sample_sw) begin
                if (conv_cnt > 11 || trial_bits != (12'h800 >> conv_cnt)) order_bad = 1;
                conv_cnt++;
            end
        end
    endtask

    // Count recovery and discharge ticks until sampling resumes.
    task automatic wait_resample();
        bit seen = 0;
        rec_cnt = 0;
        dis_cnt = 0;
        for (int i = 0; i < 600; i++) begin
            if (discharge) seen = 1;
            if (seen && !discharge) break;
            if (conv_tick) begin
                if (discharge) dis_cnt++;
                else rec_cnt++;
            end
            step();
            ctl_wr = 1'b0;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600; i++) begin
            if (!busy) break;
            step();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R10 reset busy", busy, 0);
        check("R10 reset switch open", sample_sw, 0);
        check("R12 reset irq", irq_flag, 0);
        check("R11 reset result", result, 0);
        enable = 1'b1;
        step();
        step();
        wait_resample();
        check("R8 discharge after enable", dis_cnt, 1);
        check("R8 sampling after discharge", sample_sw, 1);
    endtask

    task automatic t_convert(input logic [2:0] sel, input logic [W-1:0] v, input int exp_n);
        vin = v;
        step();
        ctl_wr = 1'b1; ctl_go = 1'b1; ctl_acq = sel;
        step();
        ctl_wr = 1'b0;
        acq_cnt = 0; conv_cnt = 0; order_bad = 0; mon_on = 1;
        step();
        if (exp_n == 0) check("R1 switch opens two edges after start", sample_sw, 0);
        else check("R2 switch held closed after start", sample_sw, 1);
        if (exp_n == 0) check("R3 busy while converting", busy, 1);
        wait_idle();
        mon_on = 0;
        if (exp_n == 0) check("R1 no acquisition periods", acq_cnt, 0);
        else check("R2 acquisition periods", acq_cnt, exp_n);
        check("R4 conversion periods", conv_cnt, 12);
        check("R4 MSB-first one-hot trial order", order_bad, 0);
        check("R4 result code", result, v);
        check("R5 irq set", irq_flag, 1);
        check("R5 switch reconnected", sample_sw, 1);
        wait_resample();
        check("R7 recovery ticks", rec_cnt, 2);
        check("R8 discharge ticks", dis_cnt, 1);
        check("R7 automatic re-sample", sample_sw, 1);
    endtask

    task automatic t_pending();
        vin = 12'h3C7;
        step();
        ctl_wr = 1'b1; ctl_go = 1'b1; ctl_acq = 3'd0;
        step();
        ctl_wr = 1'b0;
        wait_idle();
        vin = 12'h9A1;
        ctl_wr = 1'b1; ctl_go = 1'b1;
        wait_resample();
        check("R9 start held during recovery", busy, 1);
        check("R9 recovery not shortened", rec_cnt, 2);
        check("R9 discharge still done", dis_cnt, 1);
        wait_idle();
        check("R9 held start converted", result, 12'h9A1);
        wait_resample();
    endtask

    task automatic t_abort(input logic [2:0] sel, input bit in_conv);
        res_wr = 1'b1; res_wdata = 12'h5A5;
        irq_clr = 1'b1;
        step();
        res_wr = 1'b0; irq_clr = 1'b0;
        vin = 12'h123;
        ctl_wr = 1'b1; ctl_go = 1'b1; ctl_acq = sel;
        step();
        ctl_wr = 1'b0;
        acq_cnt = 0; conv_cnt = 0; order_bad = 0; mon_on = 1;
        for (int i = 0; i < 400; i++) begin
            if (in_conv && conv_cnt >= 5) break;
            if (!in_conv && acq_cnt >= 3) break;
            step();
        end
        mon_on = 0;
        ctl_wr = 1'b1; ctl_go = 1'b0;
        step();
        ctl_wr = 1'b0;
        step();
        check(in_conv ? "R6 busy cleared by abort in convert" : "R6 busy cleared by abort in timed sample", busy, 0);
        repeat (30) step();
        check(in_conv ? "R6 result kept after convert abort" : "R6 result kept after sample abort", result, 12'h5A5);
        check("R12 abort leaves irq clear", irq_flag, 0);
        check("R7 sampling resumes after abort", sample_sw, 1);
    endtask

    task automatic t_enable();
        enable = 1'b0;
        repeat (3) step();
        check("R10 disabled switch open", sample_sw, 0);
        ctl_wr = 1'b1; ctl_go = 1'b1;
        step();
        ctl_wr = 1'b0;
        step();
        check("R10 start ignored while disabled", busy, 0);
        enable = 1'b1;
        ctl_wr = 1'b1; ctl_go = 1'b1;
        step();
        ctl_wr = 1'b0;
        step();
        check("R10 start ignored on enable edge", busy, 0);
        wait_resample();
        check("R8 discharge on re-enable", dis_cnt, 1);
        repeat (20) step();
        check("R10 still idle after enable", busy, 0);
        vin = 12'hF0F;
        ctl_wr = 1'b1; ctl_go = 1'b1; ctl_acq = 3'd0;
        step();
        ctl_wr = 1'b0;
        repeat (6) step();
        enable = 1'b0;
        step();
        step();
        check("R10 disable clears busy", busy, 0);
        check("R10 disable opens switch", sample_sw, 0);
        enable = 1'b1;
        step();
        step();
        wait_resample();
    endtask

    task automatic t_result_write();
        res_wr = 1'b1; res_wdata = 12'hABC;
        step();
        res_wr = 1'b0;
        check("R11 software write readback", result, 12'hABC);
        res_wr = 1'b1; res_wdata = 12'h042;
        step();
        res_wr = 1'b0;
        step();
        check("R11 second write readback", result, 12'h042);
    endtask

    task automatic t_irq();
        repeat (25) step();
        check("R12 irq stays set", irq_flag, 1);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        check("R12 irq cleared by software", irq_flag, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_convert(3'd0, 12'h555, 0);
        t_irq();
        t_convert(3'd2, 12'hFFF, 4);
        t_convert(3'd1, 12'h000, 2);
        t_convert(3'd7, 12'h800, 20);
        t_convert(3'd5, 12'h7FF, 12);
        t_pending();
        t_abort(3'd0, 1'b1);
        t_abort(3'd7, 1'b0);
        t_result_write();
        t_enable();
        t_convert(3'd0, 12'hAAA, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule